// File: doc/BRIEF.md
# Synchronous Send Strobe Period Generator

This block sets the pace of synchronous data sends on a parallel peripheral bus. It works the same way whether the local side acts as initiator or as target. Software writes two byte-wide registers. The control byte holds a three-bit prescale code and an enable for the fast (ultra) timing class. The transfer byte holds a three-bit period code. The input clock is first divided by the prescaler, which supports divide-by 1, 2 and 4 through sparse codes. The prescaler's tick is then counted down by a period stage that divides by at least 4. Each completed divided period produces a one-cycle send strobe, provided the send enable is high. A free-running period count is also brought out.

Register writes land in a pending copy. That copy becomes active only at the end of a full divided period, so a period that has started is never cut short. When the fast timing class is disabled, any setting that would produce a strobe period shorter than the safe minimum (100 ns by default) is stretched to that minimum, and a status output is raised. A prescale code outside the three legal values raises an illegal flag and stops the dividers.

Top module: `sync_period_gen`

## Requirements
- R1: Prescale codes 3'b001, 3'b011 and 3'b101 divide the input clock by 1, 2 and 4 respectively.
- R2: Period code n divides the prescaler tick by n+4. The strobe interval in input cycles is the product of the two ratios: for example, prescale 2 with code 0 gives 8, prescale 1 with code 7 gives 11, prescale 4 with code 3 gives 28, and prescale 2 with code 4 gives 16.
- R3: Control byte bit 7 is the ultra enable and bits 6:4 are the prescale code. Transfer byte bits 7:5 are the period code. All other bits of both bytes are ignored.
- R4: When ultra is clear, an interval shorter than SAFE_DIV = ceil(SAFE_PERIOD_PS/CLK_PERIOD_PS) cycles (8 by default) is stretched. The period stage is set to ceil(SAFE_DIV/prescale), and clamped_o is 1. Otherwise clamped_o is 0.
- R5: When ultra is set, no stretching occurs: prescale 1 with period code 0 gives a 4-cycle interval, and clamped_o is 0.
- R6: An active prescale code outside the three legal values drives illegal_o to 1. While it stays active, no strobe is produced and period_cnt_o holds. Writing a legal code afterwards takes effect at once.
- R7: A register write takes effect only at the end of the divided period in progress. That period completes with its old length, and the following one uses the new setting.
- R8: strobe_o is a one-cycle pulse, once per divided period, and only while send_en_i is high. The dividers and period_cnt_o keep running when send_en_i is low.
- R9: After reset the active setting is prescale 3'b011, period code 0, ultra clear. strobe_o, illegal_o and clamped_o are 0, and strobes recur every 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctl_wr_i | input | 1 | Write strobe for the control byte |
| ctl_data_i | input | 8 | Control byte: [7] ultra enable, [6:4] prescale code |
| xfer_wr_i | input | 1 | Write strobe for the transfer byte |
| xfer_data_i | input | 8 | Transfer byte: [7:5] period code |
| send_en_i | input | 1 | Allows strobes to reach the output |
| strobe_o | output | 1 | One-cycle send strobe |
| period_cnt_o | output | PER_W | Position of the period stage within the current period |
| illegal_o | output | 1 | Active prescale code is not a legal value |
| clamped_o | output | 1 | Active setting is stretched to the safe minimum period |

## Verification
The properties assume that every legal setting gives an interval of at least four input cycles. This is true because the smallest period ratio is 4, and it is what lets the single-pulse check look only one cycle ahead. They also assume that a strobe can coincide with the first cycle of an illegal setting, since that strobe ends the last legal period, so the no-strobe check waits one cycle after illegal_o rises. The stimulus holds each write strobe for exactly one cycle with stable data. It lets at least two strobes pass after the last write before measuring an interval. It waits longer than the longest interval in use before it relies on a change having landed.

// File: rtl/sync_period_pkg.sv
package sync_period_pkg;

    typedef struct packed {
        logic       ultra;
        logic [2:0] pre_code;
        logic [2:0] per_code;
    } cfg_t;

    localparam cfg_t CFG_RST = '{ultra: 1'b0, pre_code: 3'b011, per_code: 3'b000};

    function automatic logic pre_legal(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b011) || (code == 3'b101);
    endfunction

    // log2 of the prescale ratio; only meaningful for legal codes
    function automatic logic [1:0] pre_shift(input logic [2:0] code);
        case (code)
            3'b011:  return 2'd1;
            3'b101:  return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs
    import sync_period_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ctl_wr_i,
    input  logic [7:0] ctl_data_i,
    input  logic       xfer_wr_i,
    input  logic [7:0] xfer_data_i,
    input  logic       load_i,
    output cfg_t       act_o
);

    typedef struct packed {
        cfg_t pend;
        cfg_t act;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl_wr_i) begin
            r_d.pend.ultra    = ctl_data_i[7];
            r_d.pend.pre_code = ctl_data_i[6:4];
        end
        if (xfer_wr_i) begin
            r_d.pend.per_code = xfer_data_i[7:5];
        end
        if (load_i) begin
            r_d.act = r_q.pend;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '{pend: CFG_RST, act: CFG_RST};
        end else begin
            r_q <= r_d;
        end
    end

    assign act_o = r_q.act;

endmodule

// File: rtl/sync_div_decode.sv
module sync_div_decode
    import sync_period_pkg::*;
#(
    parameter int unsigned PER_W    = 8,
    parameter int unsigned SAFE_DIV = 8
) (
    input  cfg_t             cfg_i,
    output logic             legal_o,
    output logic [1:0]       shift_o,
    output logic [PER_W-1:0] per_last_o,
    output logic             clamped_o
);

    int unsigned base_div;
    int unsigned pre_div;
    int unsigned need_div;
    int unsigned eff_div;

    always_comb begin
        legal_o  = pre_legal(cfg_i.pre_code);
        shift_o  = pre_shift(cfg_i.pre_code);
        base_div = 32'(cfg_i.per_code) + 32'd4;
        pre_div  = 32'd1 << shift_o;
        need_div = (SAFE_DIV + pre_div - 32'd1) >> shift_o;
        eff_div  = base_div;
        clamped_o = 1'b0;
        if (legal_o && !cfg_i.ultra && (need_div > base_div)) begin
            eff_div   = need_div;
            clamped_o = 1'b1;
        end
        per_last_o = PER_W'(eff_div - 32'd1);
    end

endmodule

// File: rtl/sync_prescaler.sv
module sync_prescaler #(
    parameter int unsigned PRE_W = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [1:0] shift_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_s;

    pre_s p_d, p_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        p_d    = p_q;
        last   = PRE_W'((32'd1 << shift_i) - 32'd1);
        tick_o = run_i && (p_q.cnt == last);
        if (!run_i) begin
            p_d.cnt = '0;
        end else if (tick_o) begin
            p_d.cnt = '0;
        end else begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/sync_period_stage.sv
module sync_period_stage #(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [PER_W-1:0] last_i,
    output logic             wrap_o,
    output logic [PER_W-1:0] cnt_o
);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } per_s;

    per_s c_d, c_q;

    always_comb begin
        c_d    = c_q;
        wrap_o = tick_i && (c_q.cnt == last_i);
        if (!run_i) begin
            c_d.cnt = '0;
        end else if (wrap_o) begin
            c_d.cnt = '0;
        end else if (tick_i) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o = c_q.cnt;

endmodule

// File: rtl/sync_period_gen.sv
module sync_period_gen
    import sync_period_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS  = 12500,
    parameter int unsigned SAFE_PERIOD_PS = 100000,
    parameter int unsigned PER_W          = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctl_wr_i,
    input  logic [7:0]       ctl_data_i,
    input  logic             xfer_wr_i,
    input  logic [7:0]       xfer_data_i,
    input  logic             send_en_i,
    output logic             strobe_o,
    output logic [PER_W-1:0] period_cnt_o,
    output logic             illegal_o,
    output logic             clamped_o
);

    localparam int unsigned SAFE_DIV = (SAFE_PERIOD_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned PRE_W    = 2;

    typedef struct packed {
        logic strobe;
    } out_s;

    cfg_t             act_cfg;
    logic             legal;
    logic [1:0]       shift;
    logic [PER_W-1:0] per_last;
    logic             clamp;
    logic             tick;
    logic             wrap;
    logic             load;
    logic             act_ultra;
    out_s             o_d, o_q;

    // a legal setting changes only at a period end; an illegal one is replaced at once
    assign load = wrap || !legal;

    sync_cfg_regs cfg_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctl_wr_i    (ctl_wr_i),
        .ctl_data_i  (ctl_data_i),
        .xfer_wr_i   (xfer_wr_i),
        .xfer_data_i (xfer_data_i),
        .load_i      (load),
        .act_o       (act_cfg)
    );

    sync_div_decode #(.PER_W(PER_W), .SAFE_DIV(SAFE_DIV)) dec_i (
        .cfg_i      (act_cfg),
        .legal_o    (legal),
        .shift_o    (shift),
        .per_last_o (per_last),
        .clamped_o  (clamp)
    );

    sync_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (legal),
        .shift_i (shift),
        .tick_o  (tick)
    );

    sync_period_stage #(.PER_W(PER_W)) per_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (legal),
        .tick_i (tick),
        .last_i (per_last),
        .wrap_o (wrap),
        .cnt_o  (period_cnt_o)
    );

    always_comb begin
        o_d        = o_q;
        o_d.strobe = wrap && send_en_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign strobe_o  = o_q.strobe;
    assign illegal_o = !legal;
    assign clamped_o = clamp;
    assign act_ultra = act_cfg.ultra;

endmodule

module sync_period_chk #(
    parameter int unsigned PER_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             send_en_i,
    input logic             strobe_o,
    input logic [PER_W-1:0] period_cnt_o,
    input logic             illegal_o,
    input logic             clamped_o,
    input logic             act_ultra
);

    // R8
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |=> !strobe_o);

    // R8
    strobe_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |-> $past(send_en_i));

    // R6
    illegal_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (illegal_o && $past(illegal_o)) |-> !strobe_o);

    // R6
    illegal_cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (illegal_o && $past(illegal_o)) |-> $stable(period_cnt_o));

    // R4
    clamp_only_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clamped_o |-> (!act_ultra && !illegal_o));

endmodule

bind sync_period_gen sync_period_chk #(.PER_W(PER_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .send_en_i    (send_en_i),
    .strobe_o     (strobe_o),
    .period_cnt_o (period_cnt_o),
    .illegal_o    (illegal_o),
    .clamped_o    (clamped_o),
    .act_ultra    (act_ultra)
);

// File: tb/sync_period_gen_tb.sv
module sync_period_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr, xfer_wr, send_en;
    logic [7:0] ctl_data, xfer_data;
    logic       strobe, illegal, clamped;
    logic [7:0] pcnt;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sync_period_gen dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ctl_wr_i     (ctl_wr),
        .ctl_data_i   (ctl_data),
        .xfer_wr_i    (xfer_wr),
        .xfer_data_i  (xfer_data),
        .send_en_i    (send_en),
        .strobe_o     (strobe),
        .period_cnt_o (pcnt),
        .illegal_o    (illegal),
        .clamped_o    (clamped)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_data = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_xfer(input logic [7:0] v);
        @(negedge clk); xfer_wr = 1'b1; xfer_data = v;
        @(negedge clk); xfer_wr = 1'b0;
    endtask

    // returns at the negedge on which strobe is seen; -1 on timeout
    task automatic wait_strobe(output int cyc);
        cyc = -1;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (strobe) begin
                cyc = i;
                break;
            end
        end
    endtask

    task automatic measure(input string req, input int exp);
        int c;
        wait_strobe(c);
        wait_strobe(c);
        wait_strobe(c);
        check(req, c, exp);
    endtask

    task automatic t_reset();
        check("R9 strobe", int'(strobe), 0);
        check("R9 illegal", int'(illegal), 0);
        check("R9 clamped", int'(clamped), 0);
        measure("R9 reset interval", 8);
    endtask

    task automatic t_ratios();
        wr_xfer(8'h00); wr_ctl(8'h50);
        measure("R1 prescale 4", 16);
        wr_xfer(8'h60);
        measure("R2 prescale 4 code 3", 28);
        wr_xfer(8'h80); wr_ctl(8'h30);
        measure("R2 prescale 2 code 4", 16);
        wr_xfer(8'hE0); wr_ctl(8'h10);
        measure("R2 prescale 1 code 7", 11);
        check("R4 no clamp at 11", int'(clamped), 0);
    endtask

    task automatic t_ultra_clamp();
        wr_xfer(8'h1F); wr_ctl(8'h9F);
        measure("R5 ultra 4-cycle (R3 junk bits ignored)", 4);
        check("R5 clamped low", int'(clamped), 0);
        wr_ctl(8'h10);
        measure("R4 clamped to safe", 8);
        check("R4 clamped flag", int'(clamped), 1);
    endtask

    task automatic t_boundary();
        int c;
        int k;
        wr_xfer(8'h00); wr_ctl(8'h30);
        measure("R7 base", 8);
        k = 0;
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (i == 3) begin ctl_wr = 1'b1; ctl_data = 8'h50; end
            if (i == 4) ctl_wr = 1'b0;
            if (strobe) begin k = i; break; end
        end
        ctl_wr = 1'b0;
        check("R7 period in progress kept", k, 8);
        wait_strobe(c);
        check("R7 next period new", c, 16);
    endtask

    task automatic t_send_en();
        int s = 0;
        int moves = 0;
        logic [7:0] prev;
        wr_ctl(8'h30);
        @(negedge clk); send_en = 1'b0;
        prev = pcnt;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (strobe) s++;
            if (pcnt != prev) moves++;
            prev = pcnt;
        end
        check("R8 no strobe when disabled", s, 0);
        check("R8 counter runs", int'(moves > 0), 1);
        send_en = 1'b1;
        measure("R8 resume", 8);
    endtask

    task automatic t_illegal();
        int s = 0;
        int moves = 0;
        logic [7:0] prev;
        wr_ctl(8'h00);
        repeat (40) @(negedge clk);
        check("R6 illegal flag", int'(illegal), 1);
        prev = pcnt;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (strobe) s++;
            if (pcnt != prev) moves++;
        end
        check("R6 no strobe", s, 0);
        check("R6 counter held", moves, 0);
        wr_ctl(8'h30);
        @(negedge clk);
        check("R6 flag clears at once", int'(illegal), 0);
        measure("R6 recovered interval", 8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_wr = 1'b0; xfer_wr = 1'b0;
        ctl_data = 8'h00; xfer_data = 8'h00; send_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ratios();
        t_ultra_clamp();
        t_boundary();
        t_send_en();
        t_illegal();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule